// File: doc/BRIEF.md
# Time-of-Day Counter with Read Snapshot

This block keeps a running time of day, with seconds, minutes and hours, as packed BCD bytes. A single-cycle 1 Hz tick input advances the time. Seconds and minutes wrap from 59 to 00 and carry into the next field. The hours byte works in one of two formats, picked by its own bit 6. In 24-hour format, bits 5:4 hold the tens of hours. In 12-hour format, bit 5 is a PM flag and bit 4 is the only tens bit.

A host bus reaches the three bytes through a simple port: a write strobe, an address, write data and a read-data output.

A start pulse marks the opening of each bus transaction. On that pulse the live time is copied into a shadow set of registers. Reads always return the shadow values. A multi-byte read therefore sees one consistent moment, while the live counters keep counting. Writes go straight into the live counters.

Top module: `tod_regs`

## Requirements
- R1: After reset the live time is 00:00:00 in 24-hour format (hours byte 0x00) and the shadow registers hold 0x00, so every read returns 0x00 until the first bus start.
- R2: Seconds change only on a tick. A tick adds one in packed BCD (tens in bits 6:4, units in bits 3:0), and 0x59 wraps to 0x00 with a carry into minutes.
- R3: Minutes use the same BCD encoding. They advance only on a carry out of seconds, and 0x59 wraps to 0x00 with a carry into hours.
- R4: With hours bit 6 at 0 (24-hour format), bits 5:4 are the tens of hours and bits 3:0 the units. A carry advances the hour, and 0x23 wraps to 0x00.
- R5: With hours bit 6 at 1 (12-hour format), bit 5 is the PM flag (1 = PM), bit 4 the tens and bits 3:0 the units. A carry steps the hour 12, 01, 02 … 11, 12. The PM flag flips only on the step from 11 to 12, and the step from 12 to 01 keeps it.
- R6: When wr_en is high, wr_data[6:0] is loaded into the live byte selected by addr (0 = seconds, 1 = minutes, 2 = hours) at the next edge. The following tick counts on from the written value. A tick in the same cycle as a write is dropped.
- R7: A change of format converts nothing. The hours byte keeps exactly the bits written, with bit 7 forced to 0.
- R8: On a bus_start edge the shadow registers take the live time as it stood before that edge, ignoring any tick or write in the same cycle. rd_data shows the shadow byte selected by addr (0, 1, 2) with no clock delay, and addr 3 reads 0x00.
- R9: Between bus starts the shadow registers do not change, even as the live time advances or is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_start | input | 1 | One-cycle pulse at the opening of a bus transaction |
| wr_en | input | 1 | Write strobe into the live time |
| addr | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Shadow byte selected by addr |

## Verification
The assertions assume that every byte written is a legal value for its field. Seconds and minutes must be valid BCD from 00 to 59. In 24-hour format the hours must be 00 to 23. In 12-hour format the hour field must be 01 to 12.

They also assume that tick and bus_start are single-cycle pulses. The stimulus builds every written value by converting a random integer in the legal range into BCD, so no illegal code ever reaches the counters. It drives the pulse inputs high for exactly one clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FIELD_W = 7;

  typedef struct packed {
    logic [FIELD_W-1:0] hr;
    logic [FIELD_W-1:0] mn;
    logic [FIELD_W-1:0] sc;
  } tod_time_t;

  typedef enum logic [1:0] {
    SEL_SEC = 2'd0,
    SEL_MIN = 2'd1,
    SEL_HR  = 2'd2,
    SEL_NONE = 2'd3
  } tod_sel_e;

  // Base-sixty BCD step: returns {carry, next value}
  function automatic logic [FIELD_W:0] sixty_step(input logic [FIELD_W-1:0] v);
    logic [FIELD_W:0] r;
    if (v == 7'h59)
      r = {1'b1, 7'h00};
    else if (v[3:0] == 4'd9)
      r = {1'b0, v[6:4] + 3'd1, 4'd0};
    else
      r = {1'b0, v[6:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Hours step in either format; bit 6 selects 12-hour mode and is kept
  function automatic logic [FIELD_W-1:0] hour_step(input logic [FIELD_W-1:0] h);
    logic [FIELD_W-1:0] r;
    if (h[6]) begin
      if (h[4:0] == 5'h12)
        r = {1'b1, h[5], 5'h01};
      else if (h[4:0] == 5'h11)
        r = {1'b1, ~h[5], 5'h12};
      else if (h[3:0] == 4'd9)
        r = {1'b1, h[5], 5'h10};
      else
        r = {1'b1, h[5], h[4], h[3:0] + 4'd1};
    end else begin
      if (h[5:0] == 6'h23)
        r = 7'h00;
      else if (h[3:0] == 4'd9)
        r = {1'b0, h[5:4] + 2'd1, 4'd0};
      else
        r = {1'b0, h[5:4], h[3:0] + 4'd1};
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_live.sv
module tod_live
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output tod_time_t         live
);
  tod_time_t live_q;
  logic [FIELD_W:0]   sec_next;
  logic [FIELD_W:0]   min_next;
  logic               sec_carry;
  logic               min_carry;
  logic               count_en;
  logic [FIELD_W-1:0] wr_field;

  assign wr_field  = wr_data[FIELD_W-1:0];
  assign count_en  = tick && !wr_en;
  assign sec_next  = sixty_step(live_q.sc);
  assign min_next  = sixty_step(live_q.mn);
  assign sec_carry = count_en && sec_next[FIELD_W];
  assign min_carry = sec_carry && min_next[FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (wr_en) begin
      case (tod_sel_e'(wr_addr))
        SEL_SEC: live_q.sc <= wr_field;
        SEL_MIN: live_q.mn <= wr_field;
        SEL_HR:  live_q.hr <= wr_field;
        default: ;
      endcase
    end else if (count_en) begin
      live_q.sc <= sec_next[FIELD_W-1:0];
      if (sec_carry) live_q.mn <= min_next[FIELD_W-1:0];
      if (min_carry) live_q.hr <= hour_step(live_q.hr);
    end
  end

  assign live = live_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && live_q.sc == 7'h59) |=> (live_q.sc == 7'h00)); // R2
  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && live_q.sc == 7'h59) |=> (live_q.mn != $past(live_q.mn))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(live_q)); // R2
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && live_q.hr == 7'h23) |=> (live_q.hr == 7'h00)); // R4
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && live_q.hr[6] && live_q.hr[4:0] == 5'h11)
      |=> (live_q.hr[5] != $past(live_q.hr[5]))); // R5
  AST_PM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && live_q.hr[6] && live_q.hr[4:0] == 5'h12)
      |=> (live_q.hr[5] == $past(live_q.hr[5]))); // R5
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(SEL_SEC)) |=> (live_q.sc == $past(wr_data[FIELD_W-1:0]))); // R6
endmodule

// File: rtl/tod_shadow.sv
module tod_shadow
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_start,
  input  tod_time_t live,
  output tod_time_t snap
);
  tod_time_t snap_q;
  logic      snap_take;

  assign snap_take = bus_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_take) snap_q <= live;
  end

  assign snap = snap_q;

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |=> (snap_q == $past(live))); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(snap_q)); // R9
endmodule

// File: rtl/tod_rd_mux.sv
module tod_rd_mux
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  tod_time_t         snap,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - FIELD_W;

  always_comb begin
    case (tod_sel_e'(addr))
      SEL_SEC: rd_data = {{PAD_W{1'b0}}, snap.sc};
      SEL_MIN: rd_data = {{PAD_W{1'b0}}, snap.mn};
      SEL_HR:  rd_data = {{PAD_W{1'b0}}, snap.hr};
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    AST_TOP_BIT_ZERO: assert (rd_data[DATA_W-1] == 1'b0); // R7
  end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  tod_time_t live;
  tod_time_t snap;

  tod_live #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_live (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (wr_data),
    .live    (live)
  );

  tod_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .live      (live),
    .snap      (snap)
  );

  tod_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_mux (
    .snap    (snap),
    .addr    (addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tod_regs_tb.sv
module tod_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, bus_start, wr_en;
  logic [1:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  logic [7:0] ms, mm, mh;   // model live
  logic [7:0] ss, sm, sh;   // model shadow

  always #10 clk = ~clk;

  tod_regs u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_start(bus_start),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic logic [7:0] hr_next(input logic [7:0] h);
    int  n;
    bit  pm;
    if (h[6]) begin
      n  = dec({3'b000, h[4:0]});
      pm = h[5];
      if (n == 11) pm = !pm;
      n = (n % 12) + 1;
      return 8'h40 | (pm ? 8'h20 : 8'h00) | enc(n);
    end
    n = (dec({2'b00, h[5:0]}) + 1) % 24;
    return enc(n);
  endfunction

  task automatic step(input bit t, input bit st, input bit we,
                      input logic [1:0] a, input logic [7:0] d);
    int s, m;
    @(negedge clk);
    tick = t; bus_start = st; wr_en = we; addr = a; wr_data = d;
    @(posedge clk);
    if (st) begin ss = ms; sm = mm; sh = mh; end
    if (we) begin
      case (a)
        2'd0: ms = d & 8'h7F;
        2'd1: mm = d & 8'h7F;
        2'd2: mh = d & 8'h7F;
        default: ;
      endcase
    end else if (t) begin
      s = dec(ms) + 1;
      if (s == 60) begin
        ms = 8'h00;
        m = dec(mm) + 1;
        if (m == 60) begin
          mm = 8'h00;
          mh = hr_next(mh);
        end else mm = enc(m);
      end else ms = enc(s);
    end
    #1;
    tick = 0; bus_start = 0; wr_en = 0;
  endtask

  task automatic check_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic read_model(input string req);
    check_rd(2'd0, ss, req);
    check_rd(2'd1, sm, req);
    check_rd(2'd2, sh, req);
  endtask

  task automatic snap_and_read(input string req);
    step(0, 1, 0, 2'd0, 8'h00);
    read_model(req);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    step(0, 0, 1, 2'd2, h);
    step(0, 0, 1, 2'd1, m);
    step(0, 0, 1, 2'd0, s);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst_n = 0; tick = 0; bus_start = 0; wr_en = 0; addr = 0; wr_data = 0;
    ms = 0; mm = 0; mh = 0; ss = 0; sm = 0; sh = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state before and after the first start
    check_rd(2'd0, 8'h00, "R1");
    check_rd(2'd2, 8'h00, "R1");
    check_rd(2'd3, 8'h00, "R1");
    snap_and_read("R1");

    // R2 R3 R4: 23:59:58 -> two ticks -> 00:00:00
    set_time(8'h23, 8'h59, 8'h58);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    snap_and_read("R4");
    check_rd(2'd0, 8'h00, "R2");
    check_rd(2'd1, 8'h00, "R3");
    check_rd(2'd2, 8'h00, "R4");

    // R4: tens carries 09 -> 10, 19 -> 20
    set_time(8'h09, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R4");
    check_rd(2'd2, 8'h10, "R4");
    set_time(8'h19, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R4");
    check_rd(2'd2, 8'h20, "R4");

    // R5: 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM
    set_time(8'h51, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R5");
    check_rd(2'd2, 8'h72, "R5");
    set_time(8'h72, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R5");
    check_rd(2'd2, 8'h61, "R5");
    set_time(8'h71, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R5");
    check_rd(2'd2, 8'h52, "R5");
    set_time(8'h49, 8'h59, 8'h59);
    step(1, 0, 0, 0, 0);
    snap_and_read("R5");
    check_rd(2'd2, 8'h50, "R5");

    // R7: format change keeps the raw bits, bit 7 dropped
    step(0, 0, 1, 2'd2, 8'h08);
    step(0, 0, 1, 2'd2, 8'h48);
    snap_and_read("R7");
    check_rd(2'd2, 8'h48, "R7");
    step(0, 0, 1, 2'd2, 8'hC8);
    snap_and_read("R7");
    check_rd(2'd2, 8'h48, "R7");

    // R6: write wins over a coincident tick, next tick counts on
    step(0, 0, 1, 2'd0, 8'h22);
    step(1, 0, 1, 2'd0, 8'h30);
    snap_and_read("R6");
    check_rd(2'd0, 8'h30, "R6");
    step(1, 0, 0, 0, 0);
    snap_and_read("R6");
    check_rd(2'd0, 8'h31, "R6");

    // R8: start with tick / write in the same cycle captures the earlier value
    step(0, 0, 1, 2'd0, 8'h10);
    step(1, 1, 0, 0, 0);
    read_model("R8");
    check_rd(2'd0, 8'h10, "R8");
    step(0, 1, 1, 2'd0, 8'h44);
    read_model("R8");
    check_rd(2'd0, 8'h11, "R8");

    // R9: shadow frozen while live runs and is written
    snap_and_read("R9");
    repeat (5) step(1, 0, 0, 0, 0);
    step(0, 0, 1, 2'd1, 8'h37);
    read_model("R9");
    check_rd(2'd0, 8'h44, "R9");
    snap_and_read("R9");
    check_rd(2'd1, 8'h37, "R9");
    check_rd(2'd0, 8'h49, "R9");

    // Random phase: R2 R3 R4 R5 R6 R8 R9 against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin
        int f;
        logic [7:0] v;
        f = int'($urandom_range(0, 2));
        if (f == 2) begin
          if ($urandom_range(0, 1) == 1)
            v = 8'h40 | ($urandom_range(0, 1) == 1 ? 8'h20 : 8'h00) |
                enc(int'($urandom_range(1, 12)));
          else
            v = enc(int'($urandom_range(0, 23)));
        end else begin
          v = enc(int'($urandom_range(50, 59)));
        end
        step($urandom_range(0, 1) == 1, 0, 1, 2'(f), v);
      end else if (r < 8) begin
        step($urandom_range(0, 1) == 1, 1, 0, 0, 0);
        read_model("R8");
      end else if (r < 10) begin
        read_model("R9");
      end else begin
        step($urandom_range(0, 3) != 0, 0, 0, 0, 0);
      end
    end
    snap_and_read("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule